// File: doc/BRIEF.md
# Asynchronous Serial Character Transmitter

This block turns a parallel character handed over by a host into an asynchronous serial frame on one output line. Every bit on the line lasts one bit period, which is the block clock divided by 1, 16 or 64 as chosen by a select input. A frame is a low start bit, then seven or eight data bits least significant bit first, then an optional even or odd parity bit, then one or two high stop bits. The line rests high between frames.

The data path has two stages. The host writes a character into a holding register. At the next bit boundary where the shifter is free, that character moves into the shift register. The empty flag rises straight after that move, so the next character can be written while the current one is still on the line, and frames can follow each other with no gap. A modem handshake controls the flow. The clear-to-send input must be high before a frame may start. The request-to-send output and a continuous break on the line are both set by a two-bit transmit-control input.

Top module: `sertx_top`

## Requirements
- R1: After reset the serial line is high, the holding register is empty, and `empty` equals `cts`.
- R2: Every line bit lasts exactly N clock cycles. N is 1 when `div_sel` is 2'b00, 16 when it is 2'b01, and 64 when it is 2'b10 or 2'b11.
- R3: A frame starts with one low bit, followed by the data bits least significant bit first. There are 8 data bits when `len8` is 1 and 7 data bits (bits 6..0) when `len8` is 0.
- R4: When `par_en` is 1, a parity bit follows the last data bit. With `par_odd` at 0 it makes the count of ones across the data and parity bits even. With `par_odd` at 1 it makes that count odd.
- R5: The frame ends with one high stop bit when `stop2` is 0, and with two when `stop2` is 1. The frame format is captured when the character enters the shift register.
- R6: A `load` pulse while the holding register is empty stores `din`, and `empty` is low in the next cycle. The holding register moves into the shift register on the bit boundary that ends the idle period or the last stop bit. `empty` rises in the cycle after that move. Queued characters go out back-to-back.
- R7: A `load` pulse while the holding register is full has no effect. This includes the cycle in which the holding register is being moved into the shift register.
- R8: While `cts` is low, `empty` is low and no new frame starts. A frame already on the line runs to its end.
- R9: `rts` is high when `tx_ctl[0]` is 0 and low when `tx_ctl[0]` is 1.
- R10: While `tx_ctl[1]` is 1, the line is held low and no new frame starts. When the break ends, the line follows the frame logic again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; also the clock the bit period is divided from |
| rst_n | input | 1 | Active-low synchronous reset |
| div_sel | input | 2 | Bit period select: 00 = 1 cycle, 01 = 16 cycles, 10/11 = 64 cycles |
| len8 | input | 1 | 1 = eight data bits, 0 = seven data bits |
| par_en | input | 1 | Appends a parity bit when 1 |
| par_odd | input | 1 | Parity sense: 0 = even, 1 = odd |
| stop2 | input | 1 | 1 = two stop bits, 0 = one stop bit |
| tx_ctl | input | 2 | Bit 0 = 1 drops request-to-send; bit 1 = 1 sends a continuous break |
| din | input | 8 | Character to transmit |
| load | input | 1 | Write strobe for `din` into the holding register |
| empty | output | 1 | Holding register can take a character (forced low while `cts` is low) |
| cts | input | 1 | Clear-to-send from the modem, active high |
| rts | output | 1 | Request-to-send to the modem, active high |
| txd | output | 1 | Serial output line, idles high |

## Verification
Two events can fall in the same cycle: a host write strobe and the move of the held character into the shift register. The write must be dropped, because the holding register is still full in that cycle. The bench provokes this by holding `load` high for many cycles in a row, with `din` changing every cycle, while a frame is on the line. So a strobe is present at the exact bit boundary of the move and also in the cycle after it. The reference model takes a character only in cycles where its own holding register is empty. Any wrong capture therefore shows up as a different character on the line, and `empty` and `txd` are compared against the model on every clock.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    // Frame format captured when a character enters the shift register
    typedef struct packed {
        logic len8;
        logic par_en;
        logic par_odd;
        logic stop2;
    } fmt_t;

    // Bit positions inside the transmit-control input
    localparam int CTL_RTS_OFF = 0;
    localparam int CTL_BREAK   = 1;

    // Bit period select codes
    localparam logic [1:0] DIV_SEL_ONE = 2'b00;
    localparam logic [1:0] DIV_SEL_MID = 2'b01;

endpackage

// File: rtl/sertx_divider.sv
module sertx_divider #(
    parameter int DIV_MID = 16,
    parameter int DIV_HI  = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel,
    output logic       tick
);
    import sertx_pkg::*;

    localparam int CW = $clog2(DIV_HI);
    localparam int LW = CW + 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } div_st_t;

    div_st_t       st_d, st_q;
    logic [LW-1:0] limit;

    always_comb begin
        case (sel)
            DIV_SEL_ONE: limit = LW'(1);
            DIV_SEL_MID: limit = LW'(DIV_MID);
            default:     limit = LW'(DIV_HI);
        endcase
        // greater-or-equal so a ratio change mid-count cannot overrun
        tick = ({1'b0, st_q.cnt} >= (limit - LW'(1)));
        st_d = st_q;
        if (tick) st_d.cnt = '0;
        else      st_d.cnt = st_q.cnt + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter #(
    parameter int DATA_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 start,
    input  logic [DATA_W-1:0]    data,
    input  sertx_pkg::fmt_t      fmt,
    output logic                 busy,
    output logic                 line
);
    import sertx_pkg::*;

    // data + parity + two stops; the start bit goes straight to the line
    localparam int SH_W = DATA_W + 3;
    localparam int LW   = $clog2(SH_W + 1);

    typedef struct packed {
        logic [SH_W-1:0] sh;
        logic [LW-1:0]   left;
        logic            line;
    } sh_st_t;

    sh_st_t          st_d, st_q;
    logic [SH_W-1:0] frame;
    logic [SH_W-1:0] dpad;
    logic [DATA_W-1:0] dmask;
    logic [LW-1:0]   n_dat;
    logic [LW-1:0]   n_rest;
    logic            par_bit;

    always_comb begin
        n_dat   = fmt.len8 ? LW'(DATA_W) : LW'(DATA_W - 1);
        dmask   = fmt.len8 ? {DATA_W{1'b1}} : {1'b0, {(DATA_W-1){1'b1}}};
        par_bit = (^(data & dmask)) ^ fmt.par_odd;
        dpad    = {3'b111, data};
        for (int i = 0; i < SH_W; i++) begin
            if (LW'(i) < n_dat)                    frame[i] = dpad[i];
            else if (LW'(i) == n_dat && fmt.par_en) frame[i] = par_bit;
            else                                    frame[i] = 1'b1;
        end
        n_rest = n_dat + LW'(fmt.par_en) + LW'(1) + LW'(fmt.stop2);

        st_d = st_q;
        if (tick) begin
            if (st_q.left != '0) begin
                st_d.line = st_q.sh[0];
                st_d.sh   = {1'b1, st_q.sh[SH_W-1:1]};
                st_d.left = st_q.left - LW'(1);
            end else if (start) begin
                st_d.line = 1'b0;
                st_d.sh   = frame;
                st_d.left = n_rest;
            end else begin
                st_d.line = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sh   <= '1;
            st_q.left <= '0;
            st_q.line <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = (st_q.left != '0);
    assign line = st_q.line;

endmodule

// File: rtl/sertx_top.sv
module sertx_top #(
    parameter int DATA_W  = 8,
    parameter int DIV_MID = 16,
    parameter int DIV_HI  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        div_sel,
    input  logic              len8,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              stop2,
    input  logic [1:0]        tx_ctl,
    input  logic [DATA_W-1:0] din,
    input  logic              load,
    output logic              empty,
    input  logic              cts,
    output logic              rts,
    output logic              txd
);
    import sertx_pkg::*;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              full;
    } hold_st_t;

    hold_st_t hold_d, hold_q;
    logic     tick;
    logic     start;
    logic     busy;
    logic     line;
    logic     brk;
    logic     hold_full;
    fmt_t     fmt;

    assign brk       = tx_ctl[CTL_BREAK];
    assign fmt       = '{len8: len8, par_en: par_en, par_odd: par_odd, stop2: stop2};
    assign hold_full = hold_q.full;

    sertx_divider #(.DIV_MID(DIV_MID), .DIV_HI(DIV_HI)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (div_sel),
        .tick  (tick)
    );

    assign start = tick & ~busy & hold_q.full & cts & ~brk;

    always_comb begin
        hold_d = hold_q;
        if (start) hold_d.full = 1'b0;
        if (load && !hold_q.full) begin
            hold_d.full = 1'b1;
            hold_d.data = din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    sertx_shifter #(.DATA_W(DATA_W)) u_sh (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .start (start),
        .data  (hold_q.data),
        .fmt   (fmt),
        .busy  (busy),
        .line  (line)
    );

    assign txd   = brk ? 1'b0 : line;
    assign empty = ~hold_q.full & cts;
    assign rts   = ~tx_ctl[CTL_RTS_OFF];

endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       start,
    input logic       load,
    input logic       hold_full,
    input logic       empty,
    input logic       cts,
    input logic [1:0] tx_ctl,
    input logic       txd
);

    // R8: no clear-to-send, no room reported
    a_r8_empty_needs_cts: assert property (@(posedge clk) disable iff (!rst_n)
        !cts |-> !empty);

    // R8: no frame may begin without clear-to-send
    a_r8_no_start_without_cts: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> cts);

    // R10: break forces the line low
    a_r10_break_low: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ctl[1] |-> !txd);

    // R2: the line only moves at bit boundaries
    a_r2_line_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(tick) && $stable(tx_ctl[1])) |-> $stable(txd));

    // R3: a frame begins with a low start bit
    a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !txd);

    // R6: an accepted write fills the holding register
    a_r6_load_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !hold_full) |=> !empty);

    // R7: a write into a full register cannot free it
    a_r7_full_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (load && hold_full && !start) |=> hold_full);

endmodule

bind sertx_top sertx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .start     (start),
    .load      (load),
    .hold_full (hold_full),
    .empty     (empty),
    .cts       (cts),
    .tx_ctl    (tx_ctl),
    .txd       (txd)
);

// File: tb/sim_sertx_top.sv
module sim_sertx_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] div_sel = 2'b00;
    logic       len8 = 1'b1, par_en = 1'b0, par_odd = 1'b0, stop2 = 1'b0;
    logic [1:0] tx_ctl = 2'b00;
    logic [7:0] din = 8'h00;
    logic       load = 1'b0;
    logic       cts = 1'b1;
    logic       empty, rts, txd;

    int    n_chk = 0;
    int    n_fail = 0;
    string tag = "R1";
    bit    started = 0;

    // behavioural reference state
    int         m_div = 0;
    bit         m_full = 0;
    logic [7:0] m_data = 8'h00;
    bit         m_line = 1;
    bit         m_bits[$];

    always #5 clk = ~clk;

    sertx_top u0 (
        .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .len8(len8),
        .par_en(par_en), .par_odd(par_odd), .stop2(stop2), .tx_ctl(tx_ctl),
        .din(din), .load(load), .empty(empty), .cts(cts), .rts(rts), .txd(txd)
    );

    function automatic void push_frame(logic [7:0] d);
        int  nd;
        bit  p;
        nd = len8 ? 8 : 7;
        p  = par_odd;
        for (int i = 0; i < nd; i++) begin
            m_bits.push_back(d[i]);
            p ^= d[i];
        end
        if (par_en) m_bits.push_back(p);
        m_bits.push_back(1'b1);
        if (stop2) m_bits.push_back(1'b1);
    endfunction

    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            m_div = 0; m_full = 0; m_line = 1; m_bits.delete();
        end else begin
            int lim;
            bit t, take;
            lim  = (div_sel == 2'b00) ? 1 : (div_sel == 2'b01) ? 16 : 64;
            t    = (m_div >= lim - 1);
            m_div = t ? 0 : m_div + 1;
            take = load && !m_full;
            if (t) begin
                if (m_bits.size() > 0) m_line = m_bits.pop_front();
                else if (m_full && cts && !tx_ctl[1]) begin
                    push_frame(m_data);
                    m_line = 0;
                    m_full = 0;
                end else m_line = 1;
            end
            if (take) begin
                m_full = 1;
                m_data = din;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (started) begin
            bit et;
            et = tx_ctl[1] ? 1'b0 : m_line;
            check(txd === et, tag, "txd", int'(txd), int'(et));
            check(empty === (!m_full && cts), tag, "empty", int'(empty), int'(!m_full && cts));
            check(rts === !tx_ctl[0], "R9", "rts", int'(rts), int'(!tx_ctl[0]));
        end
    end

    task automatic send(input logic [7:0] b);
        int guard = 0;
        @(negedge clk);
        while (!empty && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        din  = b;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic drain();
        int guard = 0;
        while ((m_bits.size() != 0 || m_full) && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        repeat (70) @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(txd === 1'b1, "R1", "reset txd", int'(txd), 1);
        check(empty === 1'b1, "R1", "reset empty", int'(empty), 1);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(txd === 1'b1, "R1", "idle txd", int'(txd), 1);

        // R3 / R6: 8N1 at divide-by-1, two characters back-to-back
        tag = "R3";
        send(8'hA5);
        send(8'h3C);
        tag = "R6";
        check(empty === 1'b0, "R6", "second held", int'(empty), 0);
        drain();

        // R4: parity, 7 and 8 data bits
        tag = "R4";
        len8 = 0; par_en = 1; par_odd = 0;
        send(8'hD5);
        drain();
        par_odd = 1;
        send(8'h55);
        drain();
        len8 = 1; par_odd = 0;
        send(8'hFF);
        drain();

        // R5: two stop bits
        tag = "R5";
        par_en = 0; stop2 = 1;
        send(8'h81);
        send(8'h7E);
        drain();
        stop2 = 0;

        // R2: longer bit periods
        tag = "R2";
        div_sel = 2'b01;
        send(8'h96);
        drain();
        div_sel = 2'b10;
        send(8'h01);
        drain();
        div_sel = 2'b11;
        send(8'hC3);
        drain();
        div_sel = 2'b00;

        // R7: continuous strobes while full, including the transfer cycle
        tag = "R7";
        send(8'h11);
        din  = 8'h20;
        load = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            din = din + 8'h01;
        end
        load = 1'b0;
        drain();

        // R8: clear-to-send gating
        tag = "R8";
        cts = 1'b0;
        @(negedge clk);
        check(empty === 1'b0, "R8", "empty without cts", int'(empty), 0);
        din = 8'h5A; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        repeat (30) @(negedge clk);
        check(txd === 1'b1, "R8", "no start without cts", int'(txd), 1);
        cts = 1'b1;
        repeat (3) @(negedge clk);
        cts = 1'b0;
        repeat (20) @(negedge clk);
        check(txd === 1'b1, "R8", "frame finished", int'(txd), 1);
        cts = 1'b1;
        drain();

        // R10: break holds line low and blocks a queued frame
        tag = "R10";
        tx_ctl = 2'b10;
        send(8'hE7);
        repeat (30) @(negedge clk);
        check(txd === 1'b0, "R10", "break level", int'(txd), 0);
        check(empty === 1'b0, "R10", "queued during break", int'(empty), 0);
        tx_ctl = 2'b00;
        drain();

        // R9: request-to-send control
        tag = "R9";
        tx_ctl = 2'b01;
        @(negedge clk);
        check(rts === 1'b0, "R9", "rts off", int'(rts), 0);
        tx_ctl = 2'b00;
        @(negedge clk);
        check(rts === 1'b1, "R9", "rts on", int'(rts), 1);
        repeat (5) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule